// File: doc/BRIEF.md
# Interlace-Capable Video Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a parallel RGB display link. It also produces a line index, a field flag and a line-match interrupt. Every row and column length comes from a configuration input written as the count minus one. Each axis has three phases in a fixed order: the visible area, an optional front porch, and a trailing span that holds the sync pulse. The trailing span is the "back porch" and includes the sync width.

A frame is started with a one-cycle `start` pulse. With `auto_repeat` set, frames follow one another without a gap. If `auto_repeat` is low when a frame ends, the generator stops, gives a one-cycle `done` pulse and stays idle until the next `start`.

With `interlace_en` set, the progressive engine emulates interlace. Each line-match event toggles the field flag. The vertical front porch used by a frame is the programmed value plus the field flag, so alternate fields are one line longer. In this mode the vertical sync inversion is ignored.

Top module: `ilace_timing_gen`

## Requirements
- R1: During and right after reset, de, hsync and vsync sit at their inactive levels (`de_inv`, `hs_inv`, and `vs_inv` unless `interlace_en`). `line_idx`, `field`, `match_irq` and `done` are 0.
- R2: While running, each line is `h_vis_m1+1` cycles of visible area, then the front porch, then the trailing span. The line starts in the first cycle after the `start` pulse is accepted. hsync is active in the first `h_sync_m1+1` cycles of the trailing span, clipped to the span length.
- R3: The trailing span lasts `bp_m1+1` units when its back-porch enable is set, so the sync width is counted inside it. When the back porch is disabled and sync is enabled, the span lasts `sync_m1+1` units. When both are disabled, the span is skipped.
- R4: A front porch whose enable is low takes zero units, on both the horizontal and the vertical axis.
- R5: The vertical axis follows the same region order, counted in lines. de is active only where both axes are in their visible areas. vsync is active in the first `v_sync_m1+1` lines of the vertical trailing span.
- R6: Each output equals its raw strobe XOR its inversion input (`hs_inv`, `vs_inv`, `de_inv`). `vs_inv` has no effect while `interlace_en` is 1.
- R7: With `match_en` set, `match_irq` is a one-cycle pulse in the first cycle of the line whose index equals `match_line`.
- R8: Each `match_irq` pulse toggles `field` on the next cycle when `interlace_en` is 1. `field` is unchanged when `interlace_en` is 0, and it returns to 0 when a frame is started from idle.
- R9: In interlaced mode the vertical front porch lasts `v_fp_m1+1+field` lines. Both the length and the field value are captured when the front porch is entered, so a change to `v_fp_m1` during that porch takes effect only at the next front porch.
- R10: If `auto_repeat` is 1 in the last cycle of a frame, the next frame begins in the following cycle. If it is 0, `done` pulses for one cycle in the following cycle and the outputs stay inactive until `start`. A `start` pulse while running is ignored.
- R11: `line_idx` is 0 on the first line of each frame and advances by one per line. It is held at 0 while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a frame when idle |
| auto_repeat | input | 1 | Chain frames back to back |
| interlace_en | input | 1 | Alternate the vertical front porch per field |
| h_vis_m1 | input | 12 | Visible columns minus one |
| h_fp_m1 | input | 12 | Horizontal front porch minus one |
| h_sync_m1 | input | 12 | Horizontal sync width minus one |
| h_bp_m1 | input | 12 | Horizontal trailing span (sync included) minus one |
| v_vis_m1 | input | 12 | Visible lines minus one |
| v_fp_m1 | input | 12 | Vertical front porch minus one (shorter field) |
| v_sync_m1 | input | 12 | Vertical sync width minus one |
| v_bp_m1 | input | 12 | Vertical trailing span (sync included) minus one |
| h_fp_en | input | 1 | Horizontal front porch enable |
| h_sync_en | input | 1 | Horizontal sync enable |
| h_bp_en | input | 1 | Horizontal back porch enable |
| v_fp_en | input | 1 | Vertical front porch enable |
| v_sync_en | input | 1 | Vertical sync enable |
| v_bp_en | input | 1 | Vertical back porch enable |
| hs_inv | input | 1 | Invert hsync |
| vs_inv | input | 1 | Invert vsync (progressive only) |
| de_inv | input | 1 | Invert data enable |
| match_en | input | 1 | Enable the line-match pulse |
| match_line | input | 12 | Line index that raises the match pulse |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| line_idx | output | 12 | Line index within the frame |
| field | output | 1 | Field flag |
| match_irq | output | 1 | Line-match pulse |
| done | output | 1 | Frame finished without repeat |

## Verification
The strobes, `line_idx` and `match_irq` are decoded from registered counter state. They are therefore due in the same cycle as the clock edge that moves the counters: the first visible pixel appears in the cycle right after the edge that accepts `start`. `field` and `done` come from registers one stage later. `field` changes in the cycle after the match pulse, and `done` rises in the cycle after the last cycle of the frame. The bench advances a behavioural model on every rising edge from the same inputs and compares all outputs at the falling edge. Inputs are changed just after a rising edge, so the model, the design and the comparison all see the same cycle's values.

// File: rtl/ilace_timing_pkg.sv
// Shared types for the interlace-capable timing generator.
package ilace_timing_pkg;
    // Phase of one axis within its period.
    typedef enum logic [1:0] {
        RG_ACT  = 2'd0,
        RG_FP   = 2'd1,
        RG_SPAN = 2'd2
    } region_e;
endpackage

// File: rtl/itg_axis.sv
// One timing axis: visible area, optional front porch, then a trailing
// span that carries the sync pulse. Each region length is captured when
// the region is entered, so its inputs may change while it is counted.
// Assumes lengths are given as count minus one and step is a unit tick.
module itg_axis #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] vis_m1,
    input  logic [W-1:0] fp_m1,
    input  logic [W-1:0] sync_m1,
    input  logic [W-1:0] bp_m1,
    input  logic         fp_en,
    input  logic         sync_en,
    input  logic         bp_en,
    output logic         in_act,
    output logic         in_sync,
    output logic         wrap
);
    import ilace_timing_pkg::*;

    region_e      rgn, nxt;
    logic [W-1:0] pos, lim, slim, nxt_lim;
    logic         span_en, at_end;

    assign span_en = bp_en | sync_en;
    assign at_end  = (pos == lim);

    // Pick the region that follows the current one.
    always_comb begin
        case (rgn)
            RG_ACT:  nxt = fp_en ? RG_FP : (span_en ? RG_SPAN : RG_ACT);
            RG_FP:   nxt = span_en ? RG_SPAN : RG_ACT;
            default: nxt = RG_ACT;
        endcase
    end

    // Length of the region about to be entered.
    always_comb begin
        case (nxt)
            RG_ACT:  nxt_lim = vis_m1;
            RG_FP:   nxt_lim = fp_m1;
            default: nxt_lim = bp_en ? bp_m1 : sync_m1;
        endcase
    end

    // Region, position and captured limits.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            rgn  <= RG_ACT;
            pos  <= '0;
            lim  <= vis_m1;
            slim <= '0;
        end else if (step) begin
            if (!at_end) begin
                pos <= pos + 1'b1;
            end else begin
                rgn <= nxt;
                pos <= '0;
                lim <= nxt_lim;
                if (nxt == RG_SPAN) slim <= sync_m1;
            end
        end
    end

    assign in_act  = (rgn == RG_ACT);
    assign in_sync = (rgn == RG_SPAN) && sync_en && (pos <= slim);
    assign wrap    = step && at_end && (nxt == RG_ACT);
endmodule

// File: rtl/itg_field_ctl.sv
// Line-match pulse, field flag and the per-field vertical front porch.
// Assumes line_first marks the first cycle of each line while running.
module itg_field_ctl #(
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          run,
    input  logic          line_first,
    input  logic          match_en,
    input  logic          interlace_en,
    input  logic [VW-1:0] line_idx,
    input  logic [VW-1:0] match_line,
    input  logic [VW-1:0] v_fp_m1,
    output logic          field,
    output logic          match_irq,
    output logic [VW-1:0] vfp_eff_m1
);
    assign match_irq  = run && match_en && line_first && (line_idx == match_line);
    assign vfp_eff_m1 = v_fp_m1 + {{(VW-1){1'b0}}, (interlace_en & field)};

    // Field flag: cleared on launch, toggled on match when interlaced.
    always_ff @(posedge clk) begin
        if (!rst_n || launch)               field <= 1'b0;
        else if (match_irq && interlace_en) field <= ~field;
    end
endmodule

// File: rtl/ilace_timing_gen.sv
// Top of the interlace-capable video timing generator. Runs a horizontal
// axis each clock and a vertical axis per line, applies output inversion,
// and handles start / repeat / done sequencing.
// Assumes configuration is held steady while a frame runs, except v_fp_m1.
module ilace_timing_gen #(
    parameter int HW = 12,
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          auto_repeat,
    input  logic          interlace_en,
    input  logic [HW-1:0] h_vis_m1,
    input  logic [HW-1:0] h_fp_m1,
    input  logic [HW-1:0] h_sync_m1,
    input  logic [HW-1:0] h_bp_m1,
    input  logic [VW-1:0] v_vis_m1,
    input  logic [VW-1:0] v_fp_m1,
    input  logic [VW-1:0] v_sync_m1,
    input  logic [VW-1:0] v_bp_m1,
    input  logic          h_fp_en,
    input  logic          h_sync_en,
    input  logic          h_bp_en,
    input  logic          v_fp_en,
    input  logic          v_sync_en,
    input  logic          v_bp_en,
    input  logic          hs_inv,
    input  logic          vs_inv,
    input  logic          de_inv,
    input  logic          match_en,
    input  logic [VW-1:0] match_line,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [VW-1:0] line_idx,
    output logic          field,
    output logic          match_irq,
    output logic          done
);
    logic          run, launch, line_first;
    logic          h_act, h_sync, h_wrap;
    logic          v_act, v_sync, v_wrap;
    logic [VW-1:0] vfp_eff_m1;

    assign launch = start && !run;

    itg_axis #(.W(HW)) h_axis_i (
        .clk(clk), .rst_n(rst_n), .clear(!run), .step(run),
        .vis_m1(h_vis_m1), .fp_m1(h_fp_m1), .sync_m1(h_sync_m1), .bp_m1(h_bp_m1),
        .fp_en(h_fp_en), .sync_en(h_sync_en), .bp_en(h_bp_en),
        .in_act(h_act), .in_sync(h_sync), .wrap(h_wrap)
    );

    itg_axis #(.W(VW)) v_axis_i (
        .clk(clk), .rst_n(rst_n), .clear(!run), .step(h_wrap),
        .vis_m1(v_vis_m1), .fp_m1(vfp_eff_m1), .sync_m1(v_sync_m1), .bp_m1(v_bp_m1),
        .fp_en(v_fp_en), .sync_en(v_sync_en), .bp_en(v_bp_en),
        .in_act(v_act), .in_sync(v_sync), .wrap(v_wrap)
    );

    itg_field_ctl #(.VW(VW)) field_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .run(run),
        .line_first(line_first), .match_en(match_en), .interlace_en(interlace_en),
        .line_idx(line_idx), .match_line(match_line), .v_fp_m1(v_fp_m1),
        .field(field), .match_irq(match_irq), .vfp_eff_m1(vfp_eff_m1)
    );

    // Run state and end-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= run && v_wrap && !auto_repeat;
            if (launch)                             run <= 1'b1;
            else if (run && v_wrap && !auto_repeat) run <= 1'b0;
        end
    end

    // Marks the first cycle of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) line_first <= 1'b1;
        else        line_first <= !run || h_wrap;
    end

    // Line index within the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) line_idx <= '0;
        else if (h_wrap)    line_idx <= v_wrap ? '0 : line_idx + 1'b1;
    end

    assign de    = (run && h_act && v_act) ^ de_inv;
    assign hsync = (run && h_sync) ^ hs_inv;
    assign vsync = (run && v_sync) ^ (vs_inv && !interlace_en);
endmodule

// File: rtl/ilace_timing_checker.sv
// Temporal checks on the timing generator's outputs, attached by bind.
module ilace_timing_checker #(
    parameter int VW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          interlace_en,
    input logic          hs_inv,
    input logic          de_inv,
    input logic          hsync,
    input logic          de,
    input logic          field,
    input logic          match_irq,
    input logic          done,
    input logic [VW-1:0] line_idx
);
    // R2: visible data and horizontal sync never overlap.
    a_r2_de_sync_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (de != de_inv) |-> (hsync == hs_inv));

    // R7: the match pulse lasts a single cycle.
    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        match_irq |=> !match_irq);

    // R8: a match in interlaced mode flips the field flag.
    a_r8_field_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (match_irq && interlace_en && !start) |=> (field != $past(field)));

    // R8: in progressive mode the field flag holds.
    a_r8_field_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!interlace_en && !start) |=> $stable(field));

    // R10: done is a one-cycle pulse.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10 / R11: when done, the outputs are idle and the line index is zero.
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((de == de_inv) && (line_idx == '0)));
endmodule

bind ilace_timing_gen ilace_timing_checker #(.VW(VW)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .interlace_en(interlace_en),
    .hs_inv(hs_inv), .de_inv(de_inv), .hsync(hsync), .de(de), .field(field),
    .match_irq(match_irq), .done(done), .line_idx(line_idx)
);

// File: tb/ilace_timing_gen_tb_top.sv
module ilace_timing_gen_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 0, auto_repeat = 0, interlace_en = 0;
    logic [11:0] h_vis_m1 = 7, h_fp_m1 = 1, h_sync_m1 = 2, h_bp_m1 = 5;
    logic [11:0] v_vis_m1 = 5, v_fp_m1 = 1, v_sync_m1 = 1, v_bp_m1 = 2;
    logic h_fp_en = 1, h_sync_en = 1, h_bp_en = 1;
    logic v_fp_en = 1, v_sync_en = 1, v_bp_en = 1;
    logic hs_inv = 0, vs_inv = 0, de_inv = 0, match_en = 0;
    logic [11:0] match_line = 0;
    logic hsync, vsync, de, field, match_irq, done;
    logic [11:0] line_idx;

    always #2.5 clk = ~clk;

    ilace_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .auto_repeat(auto_repeat),
        .interlace_en(interlace_en),
        .h_vis_m1(h_vis_m1), .h_fp_m1(h_fp_m1), .h_sync_m1(h_sync_m1), .h_bp_m1(h_bp_m1),
        .v_vis_m1(v_vis_m1), .v_fp_m1(v_fp_m1), .v_sync_m1(v_sync_m1), .v_bp_m1(v_bp_m1),
        .h_fp_en(h_fp_en), .h_sync_en(h_sync_en), .h_bp_en(h_bp_en),
        .v_fp_en(v_fp_en), .v_sync_en(v_sync_en), .v_bp_en(v_bp_en),
        .hs_inv(hs_inv), .vs_inv(vs_inv), .de_inv(de_inv),
        .match_en(match_en), .match_line(match_line),
        .hsync(hsync), .vsync(vsync), .de(de), .line_idx(line_idx),
        .field(field), .match_irq(match_irq), .done(done)
    );

    int    n_vec = 0, n_bad = 0;
    string cur_req = "R1";
    bit    armed = 0, ended = 0;

    // Behavioural reference state.
    bit m_run = 0, m_field = 0, m_done = 0;
    int m_hc = 0, m_vc = 0, m_fplat = 0;

    function automatic int mn(int a, int b);
        return (a < b) ? a : b;
    endfunction
    function automatic int hv();   return int'(h_vis_m1) + 1; endfunction
    function automatic int hf();   return h_fp_en ? int'(h_fp_m1) + 1 : 0; endfunction
    function automatic int hspan();
        return h_bp_en ? int'(h_bp_m1) + 1 : (h_sync_en ? int'(h_sync_m1) + 1 : 0);
    endfunction
    function automatic int hsw();  return h_sync_en ? mn(int'(h_sync_m1) + 1, hspan()) : 0; endfunction
    function automatic int vv();   return int'(v_vis_m1) + 1; endfunction
    function automatic int vspan();
        return v_bp_en ? int'(v_bp_m1) + 1 : (v_sync_en ? int'(v_sync_m1) + 1 : 0);
    endfunction
    function automatic int vsw();  return v_sync_en ? mn(int'(v_sync_m1) + 1, vspan()) : 0; endfunction

    // Advance the reference model on each rising edge.
    always @(posedge clk) begin
        bit old_f;
        armed = 1;
        if (!rst_n) begin
            m_run = 0; m_hc = 0; m_vc = 0; m_field = 0; m_done = 0; m_fplat = 0;
        end else if (!m_run) begin
            m_done = 0;
            if (start) begin m_run = 1; m_hc = 0; m_vc = 0; m_field = 0; end
        end else begin
            m_done = 0;
            old_f = m_field;
            if (match_en && interlace_en && m_hc == 0 && m_vc == int'(match_line))
                m_field = !m_field;
            m_hc++;
            if (m_hc == hv() + hf() + hspan()) begin
                m_hc = 0;
                m_vc++;
                if (m_vc == vv())
                    m_fplat = v_fp_en ? int'(v_fp_m1) + 1 + ((interlace_en && old_f) ? 1 : 0) : 0;
                if (m_vc == vv() + m_fplat + vspan()) begin
                    m_vc = 0;
                    if (!auto_repeat) begin m_run = 0; m_done = 1; end
                end
            end
        end
    end

    task automatic chk(string req, string nm, int act, int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s/%s %s act=%0d exp=%0d at %0t", cur_req, req, nm, act, exp, $time);
        end
    endtask

    // Compare all outputs against the model away from the rising edge.
    always @(negedge clk) begin
        if (armed && !ended) begin
            bit e_de, e_hs, e_vs, e_irq;
            n_vec++;
            e_de  = (m_run && m_hc < hv() && m_vc < vv()) ^ de_inv;
            e_hs  = (m_run && m_hc >= hv() + hf() && m_hc < hv() + hf() + hsw()) ^ hs_inv;
            e_vs  = (m_run && m_vc >= vv() + m_fplat && m_vc < vv() + m_fplat + vsw())
                    ^ (vs_inv && !interlace_en);
            e_irq = m_run && match_en && m_hc == 0 && m_vc == int'(match_line);
            chk("R5", "de", int'(de), int'(e_de));
            chk("R2", "hsync", int'(hsync), int'(e_hs));
            chk("R5", "vsync", int'(vsync), int'(e_vs));
            chk("R11", "line_idx", int'(line_idx), m_run ? m_vc : 0);
            chk("R8", "field", int'(field), int'(m_field));
            chk("R7", "match_irq", int'(match_irq), int'(e_irq));
            chk("R10", "done", int'(done), int'(m_done));
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic kick();
        start = 1; tick(1); start = 0;
    endtask

    task automatic finish_frames();
        auto_repeat = 0;
        while (m_run) tick(1);
        tick(3);
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL %s watchdog expired", cur_req);
        report();
    end

    initial begin
        cur_req = "R1";
        tick(4);
        rst_n = 1;
        tick(3);

        // Progressive, chained frames, then stop with done.
        cur_req = "R2";
        auto_repeat = 1;
        kick();
        tick(20);
        start = 1; tick(1); start = 0;   // ignored while running (R10)
        tick(300);
        cur_req = "R10";
        finish_frames();

        // Disabled porches and a span made only of sync.
        cur_req = "R3";
        h_bp_en = 0; v_fp_en = 0; h_fp_en = 0;
        kick();
        tick(5);
        cur_req = "R4";
        finish_frames();
        h_bp_en = 1; h_fp_en = 1; v_fp_en = 1;

        // Sync wider than the back porch: clipped.
        cur_req = "R3";
        h_sync_m1 = 9; v_sync_m1 = 6;
        kick();
        finish_frames();
        h_sync_m1 = 2; v_sync_m1 = 1;

        // Inverted outputs in progressive mode.
        cur_req = "R6";
        hs_inv = 1; vs_inv = 1; de_inv = 1;
        match_en = 1; match_line = 3;
        kick();
        cur_req = "R7";
        finish_frames();

        // Interlaced: field toggles, porch alternates, vs_inv ignored.
        cur_req = "R8";
        interlace_en = 1; match_line = 2; v_sync_m1 = 4;
        auto_repeat = 1;
        kick();
        tick(400);
        cur_req = "R9";
        do tick(1); while (!(m_run && m_vc == vv()));
        v_fp_m1 = 3;                      // change inside the porch
        tick(600);
        v_fp_m1 = 1;
        tick(400);
        finish_frames();

        // Progressive again: field stays put.
        cur_req = "R8";
        interlace_en = 0;
        kick();
        finish_frames();
        cur_req = "R11";
        tick(5);
        report();
    end
endmodule